// File: doc/BRIEF.md
# Capture Timer Channel

A single up-counting timer channel that timestamps edges on an input pin. The counter advances once per clock while it is enabled and running. Selected transitions of input `pin_a` copy the live count into capture register A and then into capture register B, so software can measure pulse widths and periods from the difference of the two. A selected edge on `pin_a` or `pin_b` can act as an external trigger that zeroes and restarts the counter. A match against a programmable compare value can do the same.

Software reaches the channel through a small word-wide register port. Address 0 is control (write), 1 is mode, 2 is the compare value, 3 is the count (read), 4 is capture A (read), 5 is capture B (read), 6 is status (read, flags clear on read) and 7 is the interrupt mask. Both pins pass through two synchronizing flops before edge detection. The interrupt line is high while any status flag whose mask bit is set is pending.

Top module: `capture_timer`

## Requirements
- R1: After reset, the count, capture A, capture B, status and mask read 0, the clock is off and `irq` is low.
- R2: Registers are selected by `addr`: 0 control, 1 mode, 2 compare, 3 count, 4 capture A, 5 capture B, 6 status, 7 mask. Control bit 0 turns the clock on, and the count then rises by one per cycle. Control bit 1 turns it off and takes priority over bit 0. Status bit 16 reads 1 while the clock is on.
- R3: Control bit 2 is a software trigger. It sets the count to 0. The count then keeps rising if the clock is on, and stays at 0 if it is off.
- R4: Mode bits 17:16 select the pin A edge that loads capture A, and bits 19:18 the edge that loads capture B, each coded 0 none, 1 rising, 2 falling, 3 both. A pin change made just after clock edge k loads the count held after edge k+2.
- R5: Capture A loads only while armed. It is armed at reset and again after each capture B load. Capture B loads only after a capture A load. Status bit 5 flags an A load and bit 6 a B load.
- R6: Status bit 1 flags a load into capture A or B whose previous value was never read through the register port.
- R7: With mode bit 6 set, a capture B load halts the count while the clock stays on, and a later trigger restarts it from 0.
- R8: With mode bit 7 set, a capture B load turns the clock off, so a later trigger leaves the count at 0.
- R9: Mode bits 9:8 select the external trigger edge (0 none, 1 rising, 2 falling, 3 both). Mode bit 10 takes the trigger from pin A instead of pin B, and the other pin is then ignored. A trigger zeroes the count and sets status bit 7.
- R10: While counting, a count equal to the compare value sets status bit 4. With mode bit 14 set, the match also restarts the count from 0 on the next cycle, so the period is compare+1.
- R11: A wrap of the count from all ones to 0 sets status bit 0.
- R12: Reading status clears flag bits 7:0, but a flag raised in the same cycle survives. `irq` is high exactly when a flag whose bit is set in the mask is pending.
- R13: With mode bit 15 set, the channel makes no captures and takes no external triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_a | input | 1 | Capture and trigger input A (asynchronous) |
| pin_b | input | 1 | Trigger input B (asynchronous) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that any trigger leaves the count at zero and that a running count steps by exactly one. They also check that a halted count holds, that a capture B load halts or switches off the clock as its mode bit says, that a wrap raises the overflow flag and that an empty mask keeps `irq` low. The capture timing through the synchronizer, the alternating load order, overrun against reads, and the edge and source selection of the trigger show only in the bench scenarios. Those scenarios drive timed pulses and compare the captured counts with values worked out from the requirements.

// File: rtl/capture_timer.sv
`timescale 1ns/1ps
module capture_timer #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        pin_a,
  input  logic        pin_b,
  output logic        irq
);
  localparam logic [2:0] R_CTRL = 3'd0, R_MODE = 3'd1, R_RC = 3'd2, R_CNT = 3'd3,
                         R_CAPA = 3'd4, R_CAPB = 3'd5, R_STAT = 3'd6, R_MASK = 3'd7;

  logic [2:0]    a_q, b_q;
  logic [31:0]   mode;
  logic [CW-1:0] rc, cnt, ra, rb;
  logic [7:0]    flags, imask;
  logic          clk_on, run, arm_b, ra_new, rb_new;

  function automatic logic hit(input logic [1:0] sel, input logic r, input logic f);
    return (sel[0] & r) | (sel[1] & f);
  endfunction

  wire a_r = a_q[1] & ~a_q[2];
  wire a_f = ~a_q[1] & a_q[2];
  wire b_r = b_q[1] & ~b_q[2];
  wire b_f = ~b_q[1] & b_q[2];

  wire cap_on   = ~mode[15];
  wire t_r      = mode[10] ? a_r : b_r;
  wire t_f      = mode[10] ? a_f : b_f;
  wire ext_trg  = cap_on & hit(mode[9:8], t_r, t_f);
  wire load_a   = cap_on & ~arm_b & hit(mode[17:16], a_r, a_f);
  wire load_b   = cap_on & arm_b & hit(mode[19:18], a_r, a_f);
  wire counting = clk_on & run;
  wire at_rc    = counting & (cnt == rc);
  wire wr_ctrl  = wr_en & (addr == R_CTRL);
  wire trig     = (wr_ctrl & wdata[2]) | ext_trg | (at_rc & mode[14]);
  wire wrap     = counting & ~trig & (&cnt);
  wire ovr      = (load_a & ra_new) | (load_b & rb_new);
  wire rd_stat  = rd_en & (addr == R_STAT);
  wire rb_halt  = load_b & (mode[6] | mode[7]);

  wire clk_on_n = ((wr_ctrl & wdata[1]) | (load_b & mode[7])) ? 1'b0 :
                  (wr_ctrl & wdata[0]) ? 1'b1 : clk_on;
  wire run_n    = (~clk_on_n | rb_halt) ? 1'b0 :
                  (trig | (wr_ctrl & wdata[0])) ? 1'b1 : run;

  wire [7:0] flag_set = {ext_trg, load_b, load_a, at_rc, 2'b00, ovr, wrap};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0;
      mode <= '0; rc <= '0; imask <= '0;
      cnt <= '0; ra <= '0; rb <= '0; flags <= '0;
      clk_on <= 1'b0; run <= 1'b0; arm_b <= 1'b0;
      ra_new <= 1'b0; rb_new <= 1'b0;
    end else begin
      a_q <= {a_q[1:0], pin_a};
      b_q <= {b_q[1:0], pin_b};
      if (wr_en && addr == R_MODE) mode  <= wdata;
      if (wr_en && addr == R_RC)   rc    <= wdata[CW-1:0];
      if (wr_en && addr == R_MASK) imask <= wdata[7:0];
      clk_on <= clk_on_n;
      run    <= run_n;
      if (trig)          cnt <= '0;
      else if (counting) cnt <= cnt + 1'b1;
      if (load_a) begin
        ra <= cnt; arm_b <= 1'b1; ra_new <= 1'b1;
      end else if (rd_en && addr == R_CAPA) ra_new <= 1'b0;
      if (load_b) begin
        rb <= cnt; arm_b <= 1'b0; rb_new <= 1'b1;
      end else if (rd_en && addr == R_CAPB) rb_new <= 1'b0;
      flags <= (rd_stat ? 8'h00 : flags) | flag_set;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      R_MODE: rdata = mode;
      R_RC:   rdata[CW-1:0] = rc;
      R_CNT:  rdata[CW-1:0] = cnt;
      R_CAPA: rdata[CW-1:0] = ra;
      R_CAPB: rdata[CW-1:0] = rb;
      R_STAT: rdata = {15'd0, clk_on, 8'd0, flags};
      R_MASK: rdata[7:0] = imask;
      default: rdata = '0;
    endcase
  end

  assign irq = |(flags & imask);
endmodule

module capture_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          counting,
  input logic          load_b,
  input logic          stop_cfg,
  input logic          dis_cfg,
  input logic          run,
  input logic          clk_on,
  input logic          wrap,
  input logic          ovf_flag,
  input logic          irq,
  input logic [7:0]    imask,
  input logic [CW-1:0] cnt
);
  // R3
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cnt == '0);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    counting && !trig |=> cnt == CW'($past(cnt) + 1'b1));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !counting && !trig |=> $stable(cnt));
  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_b && stop_cfg |=> !run);
  // R8
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_b && dis_cfg |=> !clk_on);
  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imask == 8'h00 |-> !irq);
endmodule

bind capture_timer capture_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .counting(counting), .load_b(load_b),
  .stop_cfg(mode[6]), .dis_cfg(mode[7]), .run(run), .clk_on(clk_on),
  .wrap(wrap), .ovf_flag(flags[0]), .irq(irq), .imask(imask), .cnt(cnt)
);

// File: tb/sim_capture_timer.sv
`timescale 1ns/1ps
module sim_capture_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, pin_a = 1'b0, pin_b = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  capture_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .irq(irq));

  // {A edge code, B edge code, expected capture A, expected capture B, expected status & 0x62}
  // Pin A rises at cycle 10, falls at 15, rises at 30 (captures 12, 17, 32): R4 R5 R6
  localparam logic [43:0] VECS [0:6] = '{
    {2'd1, 2'd2, 16'd32, 16'd17, 8'h62},
    {2'd2, 2'd1, 16'd17, 16'd32, 8'h60},
    {2'd1, 2'd1, 16'd12, 16'd32, 8'h60},
    {2'd3, 2'd3, 16'd32, 16'd17, 8'h62},
    {2'd0, 2'd1, 16'd0,  16'd0,  8'h00},
    {2'd3, 2'd0, 16'd12, 16'd0,  8'h20},
    {2'd2, 2'd2, 16'd17, 16'd0,  8'h20}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_a = 1'b0; pin_b = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic two_edges();
    step(10); pin_a = 1'b1;
    step(5);  pin_a = 1'b0;
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd3, v); check("R1 count", v, 32'd0);
    rd(3'd6, v); check("R1 status", v, 32'd0);
    rd(3'd4, v); check("R1 capture A", v, 32'd0);
    rd(3'd7, v); check("R1 mask", v, 32'd0);

    for (int i = 0; i < 7; i++) begin
      do_reset();
      wr(3'd1, (32'(VECS[i][43:42]) << 16) | (32'(VECS[i][41:40]) << 18));
      wr(3'd0, 32'd1);
      two_edges();
      step(15); pin_a = 1'b1;
      step(10);
      rd(3'd4, v); check($sformatf("R4 R5 vec%0d capture A", i), v, 32'(VECS[i][39:24]));
      rd(3'd5, v); check($sformatf("R4 R5 vec%0d capture B", i), v, 32'(VECS[i][23:8]));
      rd(3'd6, v); check($sformatf("R5 R6 vec%0d status", i), v & 32'h62, 32'(VECS[i][7:0]));
    end

    // R2 counting, enable/disable
    do_reset();
    wr(3'd0, 32'd1);
    step(7);
    rd(3'd3, v); check("R2 count after 7", v, 32'd7);
    rd(3'd6, v); check("R2 clock on bit", (v >> 16) & 1, 32'd1);
    wr(3'd0, 32'd2);
    step(5);
    rd(3'd3, v); check("R2 count frozen", v, 32'd10);
    wr(3'd0, 32'd1);
    wr(3'd0, 32'd3);
    rd(3'd6, v); check("R2 disable wins", (v >> 16) & 1, 32'd0);

    // R3 software trigger
    do_reset();
    wr(3'd0, 32'd1);
    step(20);
    wr(3'd0, 32'd4);
    step(4);
    rd(3'd3, v); check("R3 restart", v, 32'd4);
    wr(3'd0, 32'd2);
    wr(3'd0, 32'd4);
    step(3);
    rd(3'd3, v); check("R3 trigger while off", v, 32'd0);

    // R7 stop on capture B load
    do_reset();
    wr(3'd1, (32'd1 << 16) | (32'd2 << 18) | (32'd1 << 6));
    wr(3'd0, 32'd1);
    two_edges();
    step(20);
    rd(3'd3, v); check("R7 halted count", v, 32'd18);
    rd(3'd6, v); check("R7 clock still on", (v >> 16) & 1, 32'd1);
    rd(3'd5, v); check("R7 capture B", v, 32'd17);
    wr(3'd0, 32'd4);
    step(5);
    rd(3'd3, v); check("R7 restart by trigger", v, 32'd5);

    // R8 disable on capture B load
    do_reset();
    wr(3'd1, (32'd1 << 16) | (32'd2 << 18) | (32'd1 << 7));
    wr(3'd0, 32'd1);
    two_edges();
    step(20);
    rd(3'd3, v); check("R8 halted count", v, 32'd18);
    rd(3'd6, v); check("R8 clock off", (v >> 16) & 1, 32'd0);
    wr(3'd0, 32'd4);
    step(5);
    rd(3'd3, v); check("R8 no restart", v, 32'd0);

    // R9 external trigger from pin B, rising
    do_reset();
    wr(3'd1, 32'd1 << 8);
    wr(3'd0, 32'd1);
    step(20); pin_b = 1'b1;
    step(10);
    rd(3'd3, v); check("R9 pin B trigger", v, 32'd7);
    rd(3'd6, v); check("R9 trigger flag", v & 32'h80, 32'h80);

    // R9 source pin A: pin B ignored
    do_reset();
    wr(3'd1, (32'd1 << 8) | (32'd1 << 10));
    wr(3'd0, 32'd1);
    step(20); pin_b = 1'b1;
    step(10);
    rd(3'd3, v); check("R9 pin B ignored", v, 32'd30);
    pin_a = 1'b1;
    step(6);
    rd(3'd3, v); check("R9 pin A trigger", v, 32'd3);

    // R10 compare
    do_reset();
    wr(3'd2, 32'd9);
    wr(3'd1, 32'd1 << 14);
    wr(3'd0, 32'd1);
    step(25);
    rd(3'd3, v); check("R10 compare restart", v, 32'd5);
    rd(3'd6, v); check("R10 compare flag", v & 32'h10, 32'h10);
    do_reset();
    wr(3'd2, 32'd9);
    wr(3'd0, 32'd1);
    step(25);
    rd(3'd3, v); check("R10 no restart when off", v, 32'd25);

    // R11 overflow, R12 interrupt mask and clear on read
    do_reset();
    wr(3'd7, 32'd1);
    wr(3'd0, 32'd1);
    step(100);
    check("R12 masked flag no irq", {31'd0, irq}, 32'd0);
    step(65439);
    check("R12 irq on overflow", {31'd0, irq}, 32'd1);
    rd(3'd3, v); check("R11 wrapped count", v, 32'd3);
    rd(3'd6, v); check("R11 overflow flag", v & 32'h1, 32'h1);
    check("R12 irq cleared by read", {31'd0, irq}, 32'd0);
    rd(3'd6, v); check("R12 flag cleared", v & 32'h1, 32'h0);

    // R13 capture mode off
    do_reset();
    wr(3'd1, (32'd1 << 15) | (32'd1 << 16) | (32'd1 << 8));
    wr(3'd0, 32'd1);
    step(10); pin_a = 1'b1; pin_b = 1'b1;
    step(10);
    rd(3'd4, v); check("R13 no capture", v, 32'd0);
    rd(3'd3, v); check("R13 no trigger", v, 32'd21);

    // R6 no overrun when capture A read in between
    do_reset();
    wr(3'd1, (32'd1 << 16) | (32'd2 << 18));
    wr(3'd0, 32'd1);
    two_edges();
    step(5);
    rd(3'd4, v); check("R5 first capture A", v, 32'd12);
    step(9); pin_a = 1'b1;
    step(10);
    rd(3'd6, v); check("R6 no overrun", v & 32'h2, 32'h0);
    rd(3'd4, v); check("R5 second capture A", v, 32'd32);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule